// File: doc/BRIEF.md
# Timer Status Flag and Interrupt Request Unit

This block keeps the three status flags of one timer/counter: a flag for a match against compare value A, a flag for a match against compare value B, and an overflow flag. The counter core drives single-cycle event strobes into the block. The block turns these strobes into sticky flags, combines them with a global enable and a per-flag enable to form three interrupt requests, and shows the flags on a read port.

The overflow flag is set by a different event depending on the counting mode. In the dual-slope mode it follows the counter's arrival at BOTTOM. In every other mode it follows the wrap from TOP to BOTTOM. Each flag can be cleared in two ways. The interrupt controller can acknowledge the vector, and the clear then takes effect at the next edge. Software can also write a one to the flag's bit, and that clear takes effect only after a synchronization delay. If a new event and a clear arrive in the same cycle, the event wins, so no event is lost.

Top module: `tmr_flag_irq`

## Requirements
- R1: A high `cmp_a_i` at a clock edge sets `flag_a_o` after that edge. `flag_a_o` never rises without that strobe in the cycle before.
- R2: A high `cmp_b_i` at a clock edge sets `flag_b_o` after that edge.
- R3: With `mode_i` at 2'b00 (normal), 2'b01 (fast single-slope) or 2'b11 (reserved, treated like normal), `top_wrap_i` sets `flag_ovf_o` after the edge, and `bottom_i` has no effect on it.
- R4: With `mode_i` at 2'b10 (dual-slope), `bottom_i` sets `flag_ovf_o` after the edge, and `top_wrap_i` has no effect on it.
- R5: A high acknowledge input (`ack_a_i`, `ack_b_i`, `ack_ovf_i`) at an edge clears its flag after that edge.
- R6: A write (`wr_en_i` high) clears each flag whose bit in `wr_data_i` is one, using bit 6 for A, bit 5 for B and bit 2 for overflow. Zero bits and all other bit positions leave the flags unchanged.
- R7: With the default SYNC_STAGES of 1, a write-one clear sampled at edge n leaves the flag still reading one after edge n. The flag reads zero after edge n+1.
- R8: Each of `irq_a_o`, `irq_b_o` and `irq_ovf_o` is high exactly when `gie_i`, its own enable input and its flag are all high.
- R9: `rd_data_o` carries flag A in bit 6, flag B in bit 5 and the overflow flag in bit 2. All other bits read zero.
- R10: When a set event meets an acknowledge or a maturing write clear at the same edge, the flag ends up set.
- R11: While `rst_n` is low, all flags, requests and read bits are zero, and any pending write clears are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Counting mode; 2'b10 selects dual-slope |
| cmp_a_i | input | 1 | Strobe: counter matched compare value A |
| cmp_b_i | input | 1 | Strobe: counter matched compare value B |
| top_wrap_i | input | 1 | Strobe: counter at TOP, reloading BOTTOM |
| bottom_i | input | 1 | Strobe: counter reaching BOTTOM |
| wr_en_i | input | 1 | Flag register write strobe |
| wr_data_i | input | 8 | Write data; ones clear flags |
| gie_i | input | 1 | Global interrupt enable |
| en_a_i | input | 1 | Interrupt enable for flag A |
| en_b_i | input | 1 | Interrupt enable for flag B |
| en_ovf_i | input | 1 | Interrupt enable for overflow flag |
| ack_a_i | input | 1 | Vector A acknowledge |
| ack_b_i | input | 1 | Vector B acknowledge |
| ack_ovf_i | input | 1 | Overflow vector acknowledge |
| flag_a_o | output | 1 | Compare A flag |
| flag_b_o | output | 1 | Compare B flag |
| flag_ovf_o | output | 1 | Overflow flag |
| irq_a_o | output | 1 | Compare A interrupt request |
| irq_b_o | output | 1 | Compare B interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| rd_data_o | output | 8 | Flag register read data |

## Verification
A wrong flag bit shows on `rd_data_o` and on the flag output in the cycle after the faulty edge. When the enables are on, it also shows on the matching request. A corrupted pending write clear stays hidden for SYNC_STAGES edges and then appears as a flag that drops too early, too late or not at all. A wrong overflow event choice shows only when the two counter strobes differ under a given mode. For these reasons the bench compares every output against a reference model on every cycle, and it drives the two strobes separately under each mode.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_FAST   = 2'b01,
        MODE_DUAL   = 2'b10,
        MODE_RSVD   = 2'b11
    } cnt_mode_e;

    localparam int unsigned NUM_FLAGS = 3;
    localparam int unsigned IDX_A     = 0;
    localparam int unsigned IDX_B     = 1;
    localparam int unsigned IDX_OVF   = 2;

endpackage

// File: rtl/tmr_ovf_sel.sv
module tmr_ovf_sel
    import tmr_flag_pkg::*;
(
    input  cnt_mode_e mode_i,
    input  logic      top_wrap_i,
    input  logic      bottom_i,
    output logic      ovf_evt_o
);

    always_comb begin
        unique case (mode_i)
            MODE_DUAL: ovf_evt_o = bottom_i;
            default:   ovf_evt_o = top_wrap_i;
        endcase
    end

endmodule

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell #(
    parameter int unsigned SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hw_clr_i,
    input  logic sw_clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic                   flag;
        logic [SYNC_STAGES-1:0] pend;
    } cell_st_t;

    cell_st_t st_d, st_q;
    logic     mature;

    assign mature = st_q.pend[SYNC_STAGES-1];

    always_comb begin
        st_d         = st_q;
        st_d.pend[0] = sw_clr_i;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            st_d.pend[i] = st_q.pend[i-1];
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (hw_clr_i || mature) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R1
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R5
    hw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_clr_i && !set_i) |=> !flag_o);

    // R7
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mature && !set_i) |=> !flag_o);

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !hw_clr_i && !mature) |=> $stable(flag_o));

endmodule

// File: rtl/tmr_flag_irq.sv
module tmr_flag_irq
    import tmr_flag_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned A_BIT       = 6,
    parameter int unsigned B_BIT       = 5,
    parameter int unsigned OVF_BIT     = 2,
    parameter int unsigned SYNC_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              cmp_a_i,
    input  logic              cmp_b_i,
    input  logic              top_wrap_i,
    input  logic              bottom_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              gie_i,
    input  logic              en_a_i,
    input  logic              en_b_i,
    input  logic              en_ovf_i,
    input  logic              ack_a_i,
    input  logic              ack_b_i,
    input  logic              ack_ovf_i,
    output logic              flag_a_o,
    output logic              flag_b_o,
    output logic              flag_ovf_o,
    output logic              irq_a_o,
    output logic              irq_b_o,
    output logic              irq_ovf_o,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int unsigned NF = NUM_FLAGS;

    cnt_mode_e     mode;
    logic          ovf_evt;
    logic [NF-1:0] set_vec, ack_vec, wclr_vec, en_vec, flag_vec, irq_vec;

    assign mode = cnt_mode_e'(mode_i);

    tmr_ovf_sel u_ovf_sel (
        .mode_i     (mode),
        .top_wrap_i (top_wrap_i),
        .bottom_i   (bottom_i),
        .ovf_evt_o  (ovf_evt)
    );

    always_comb begin
        set_vec[IDX_A]    = cmp_a_i;
        set_vec[IDX_B]    = cmp_b_i;
        set_vec[IDX_OVF]  = ovf_evt;
        ack_vec[IDX_A]    = ack_a_i;
        ack_vec[IDX_B]    = ack_b_i;
        ack_vec[IDX_OVF]  = ack_ovf_i;
        wclr_vec[IDX_A]   = wr_en_i && wr_data_i[A_BIT];
        wclr_vec[IDX_B]   = wr_en_i && wr_data_i[B_BIT];
        wclr_vec[IDX_OVF] = wr_en_i && wr_data_i[OVF_BIT];
        en_vec[IDX_A]     = en_a_i;
        en_vec[IDX_B]     = en_b_i;
        en_vec[IDX_OVF]   = en_ovf_i;
    end

    for (genvar g = 0; g < int'(NF); g++) begin : g_flag
        tmr_flag_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_vec[g]),
            .hw_clr_i (ack_vec[g]),
            .sw_clr_i (wclr_vec[g]),
            .flag_o   (flag_vec[g])
        );
    end

    always_comb begin
        irq_vec            = flag_vec & en_vec & {NF{gie_i}};
        rd_data_o          = '0;
        rd_data_o[A_BIT]   = flag_vec[IDX_A];
        rd_data_o[B_BIT]   = flag_vec[IDX_B];
        rd_data_o[OVF_BIT] = flag_vec[IDX_OVF];
    end

    assign flag_a_o   = flag_vec[IDX_A];
    assign flag_b_o   = flag_vec[IDX_B];
    assign flag_ovf_o = flag_vec[IDX_OVF];
    assign irq_a_o    = irq_vec[IDX_A];
    assign irq_b_o    = irq_vec[IDX_B];
    assign irq_ovf_o  = irq_vec[IDX_OVF];

    // R4
    dual_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b10 && bottom_i) |=> flag_ovf_o);

    // R3
    std_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b10 && top_wrap_i) |=> flag_ovf_o);

    // R1
    a_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a_o) |-> $past(cmp_a_i));

    // R8
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_i |-> (!irq_a_o && !irq_b_o && !irq_ovf_o));

endmodule

// File: tb/tmr_flag_irq_bench.sv
module tmr_flag_irq_bench;

    localparam int SYNC = 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode;
    logic       cmp_a, cmp_b, top_wrap, bottom, wr_en, gie;
    logic       en_a, en_b, en_ovf, ack_a, ack_b, ack_ovf;
    logic [7:0] wr_data;
    logic       flag_a, flag_b, flag_ovf, irq_a, irq_b, irq_ovf;
    logic [7:0] rd_data;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    bit         mf [3];
    logic [2:0] clrq[$];

    always #5 clk = ~clk;

    tmr_flag_irq u_tmr_flag_irq (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .cmp_a_i(cmp_a), .cmp_b_i(cmp_b), .top_wrap_i(top_wrap), .bottom_i(bottom),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .gie_i(gie),
        .en_a_i(en_a), .en_b_i(en_b), .en_ovf_i(en_ovf),
        .ack_a_i(ack_a), .ack_b_i(ack_b), .ack_ovf_i(ack_ovf),
        .flag_a_o(flag_a), .flag_b_o(flag_b), .flag_ovf_o(flag_ovf),
        .irq_a_o(irq_a), .irq_b_o(irq_b), .irq_ovf_o(irq_ovf),
        .rd_data_o(rd_data)
    );

    // Reference model: updates on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) mf[i] = 1'b0;
            clrq = {};
            for (int i = 0; i < SYNC; i++) clrq.push_back(3'b000);
        end else begin
            logic [2:0] mat, wm, setv, ackv;
            mat  = clrq.pop_front();
            wm   = wr_en ? {wr_data[2], wr_data[5], wr_data[6]} : 3'b000;
            clrq.push_back(wm);
            setv = {(mode == 2'b10) ? bottom : top_wrap, cmp_b, cmp_a};
            ackv = {ack_ovf, ack_b, ack_a};
            for (int i = 0; i < 3; i++) begin
                if (setv[i])                 mf[i] = 1'b1;
                else if (ackv[i] || mat[i])  mf[i] = 1'b0;
            end
        end
    end

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare(string tag);
        logic [7:0] erd;
        erd = 8'h00;
        erd[6] = mf[0]; erd[5] = mf[1]; erd[2] = mf[2];
        chk(tag, "flags", {5'b0, flag_ovf, flag_b, flag_a}, {5'b0, mf[2], mf[1], mf[0]});
        chk(tag, "irqs", {5'b0, irq_ovf, irq_b, irq_a},
            {5'b0, gie & en_ovf & mf[2], gie & en_b & mf[1], gie & en_a & mf[0]});
        chk(tag, "rd_data", rd_data, erd);
    endtask

    task automatic idle();
        cmp_a = 0; cmp_b = 0; top_wrap = 0; bottom = 0;
        wr_en = 0; wr_data = 8'h00; ack_a = 0; ack_b = 0; ack_ovf = 0;
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst_n = 0; mode = 2'b00; gie = 0; en_a = 0; en_b = 0; en_ovf = 0;
        idle();
        @(negedge clk);
        cmp_a = 1; bottom = 1;
        repeat (3) tick("R11");
        idle();
        rst_n = 1;
        tick("R11");
        cmp_a = 1; tick("R1"); idle();
        cmp_b = 1; tick("R2"); idle();
        bottom = 1; tick("R3"); idle();
        top_wrap = 1; tick("R3"); idle();
        gie = 1; en_a = 1; en_b = 1; en_ovf = 1; tick("R8");
        gie = 0; tick("R8");
        gie = 1; en_a = 0; en_ovf = 0; tick("R8");
        ack_a = 1; tick("R5"); idle();
        tick("R9");
        wr_en = 1; wr_data = 8'hBB; tick("R6"); idle();
        tick("R7");
        tick("R7");
        ack_ovf = 1; tick("R5"); idle();
        mode = 2'b10; top_wrap = 1; tick("R4"); idle();
        bottom = 1; tick("R4"); idle();
        mode = 2'b11; ack_ovf = 1; tick("R5"); idle();
        top_wrap = 1; tick("R3"); idle();
        cmp_a = 1; ack_a = 1; tick("R10"); idle();
        wr_en = 1; wr_data = 8'h40; tick("R10"); idle();
        cmp_a = 1; tick("R10"); idle();
        tick("R10");
        en_a = 1; en_ovf = 1;
        for (int n = 0; n < 3000; n++) begin
            mode     = 2'($urandom);
            cmp_a    = ($urandom % 4) == 0;
            cmp_b    = ($urandom % 4) == 0;
            top_wrap = ($urandom % 5) == 0;
            bottom   = ($urandom % 5) == 0;
            ack_a    = ($urandom % 6) == 0;
            ack_b    = ($urandom % 6) == 0;
            ack_ovf  = ($urandom % 6) == 0;
            wr_en    = ($urandom % 4) == 0;
            wr_data  = 8'($urandom);
            gie      = ($urandom % 8) != 0;
            en_b     = 1'($urandom);
            rst_n    = ($urandom % 500) != 0;
            tick("R9");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule